// File: doc/BRIEF.md
# Dual-Mode Programmable Clock Divider

The block takes a base clock and produces two outputs. One is the base clock, gated by an enable. The other is a divided clock set by an 8-bit divide value N and a mode bit. With the mode bit clear, the divided output gives one base-cycle-wide high pulse every N+1 base cycles. When N is zero, the base clock passes straight through. With the mode bit set, the divided output is a square wave with a 50% duty cycle and a period of 2(N+1) base cycles.

The settings come in on plain register inputs. These are an 8-bit divide value and a control byte that holds the mode bit and the two enables. A new divide value, a new mode or a new divided-output enable is taken only when the running period ends, so no output phase is ever cut short. The base-output enable is taken while the base clock is low.

Top module: `progClockDivider`

## Requirements
- R1: With control bit 0 (mode) at 0 and N from 1 to 255, the divided output has a period of N+1 base cycles and is high for exactly one base cycle of each period.
- R2: With mode 0 and N = 0, the divided output follows the base clock when enabled: high during the high phase and low during the low phase of every cycle.
- R3: With mode 1, the divided output has a period of 2(N+1) base cycles and is high for N+1 of them.
- R4: Control bit 1 (factory test, kept at 0 by software) and control bits 7:4 have no effect on either output.
- R5: With control bit 2 set, the base output equals the base clock. With it clear, the base output is held low. An enable change takes effect within two base cycles.
- R6: With control bit 3 clear, the divided output is held low.
- R7: A change of the divide value or of the mode takes effect only at the end of the running period. The period in progress completes with the old settings.
- R8: A change of control bit 3 takes effect only at a period boundary. A high phase already in progress runs to its full length.
- R9: While reset is asserted, both outputs are low and the mode is 0.
- R10: The slowest settings, N = 255, give a period of 256 base cycles in mode 0 and 512 base cycles in mode 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divSel | input | 8 | Divide value N |
| ctrlByte | input | 8 | bit0 mode, bit1 test (keep 0), bit2 base enable, bit3 divided enable, bits 7:4 unused |
| baseOut | output | 1 | Gated base clock |
| divOut | output | 1 | Divided clock |

## Verification
Two events can fall on the same base edge: a change of the divide value or enable, and the end of a period. The bench provokes this by changing the settings in the cycle right after it sees a rising edge of the divided output, which is the edge that ended the previous period. It then measures the period, or the length of the high phase, that follows. That period must still match the old settings, and only the next period may show the new ones. A mid-high-phase disable in mode 1 must leave a high phase of the full N+1 cycles, after which the output stays low.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  localparam int MODE_BIT    = 0;
  localparam int TEST_BIT    = 1;
  localparam int BASE_EN_BIT = 2;
  localparam int DIV_EN_BIT  = 3;

  typedef struct packed {
    logic periodEnd;  // full period finishes at this edge
    logic halfEnd;    // mode 1 high half finishes at this edge
    logic holdLevel;  // running mode is 50% duty (keep level between strobes)
    logic passNext;   // settings being loaded select base pass-through
  } divStrobe_t;
endpackage

// File: rtl/pcdControl.sv
module pcdControl
  import pcd_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic             modeBit,
  output divStrobe_t       strobe
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] actN;
  logic             actMode;
  logic             phase;
  logic             atLimit;

  assign atLimit          = (cnt == actN);
  assign strobe.periodEnd = atLimit && (!actMode || phase);
  assign strobe.halfEnd   = atLimit && actMode && !phase;
  assign strobe.holdLevel = actMode;
  assign strobe.passNext  = (divSel == '0) && !modeBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      actN    <= '0;
      actMode <= 1'b0;
      phase   <= 1'b0;
    end else if (strobe.periodEnd) begin
      cnt     <= '0;
      actN    <= divSel;
      actMode <= modeBit;
      phase   <= 1'b0;
    end else if (strobe.halfEnd) begin
      cnt   <= '0;
      phase <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= actN);

  // R7
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.periodEnd |=> ($stable(actN) && $stable(actMode)));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase && !strobe.periodEnd) |=> phase);
endmodule

// File: rtl/pcdDatapath.sv
module pcdDatapath
  import pcd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  divStrobe_t strobe,
  input  logic       divEnIn,
  input  logic       baseEnIn,
  output logic       baseOut,
  output logic       divOut
);
  logic actEn;
  logic outQ;
  logic passQ;
  logic baseGateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEn <= 1'b0;
      outQ  <= 1'b0;
      passQ <= 1'b0;
    end else if (strobe.periodEnd) begin
      actEn <= divEnIn;
      outQ  <= divEnIn;
      passQ <= divEnIn && strobe.passNext;
    end else if (strobe.halfEnd) begin
      outQ <= 1'b0;
    end else if (!strobe.holdLevel) begin
      outQ <= 1'b0;
    end
  end

  // enable sampled on the falling edge so the gate only moves while clk is low
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) baseGateQ <= 1'b0;
    else       baseGateQ <= baseEnIn;
  end

  assign baseOut = clk & baseGateQ;
  assign divOut  = passQ ? clk : outQ;

  // R6
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !actEn |-> (!outQ && !passQ));

  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outQ && !passQ && !strobe.holdLevel && !strobe.periodEnd) |=> !outQ);

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.holdLevel && !strobe.periodEnd && !strobe.halfEnd) |=> $stable(outQ));
endmodule

// File: rtl/progClockDivider.sv
module progClockDivider
  import pcd_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divSel,
  input  logic [CTRL_W-1:0] ctrlByte,
  output logic              baseOut,
  output logic              divOut
);
  divStrobe_t strobe;
  logic       unusedCtrl;

  // R4: test bit and upper bits are not decoded
  assign unusedCtrl = ^{ctrlByte[CTRL_W-1:DIV_EN_BIT+1], ctrlByte[TEST_BIT]};

  pcdControl #(.DIV_W(DIV_W)) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divSel  (divSel),
    .modeBit (ctrlByte[MODE_BIT]),
    .strobe  (strobe)
  );

  pcdDatapath i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .divEnIn  (ctrlByte[DIV_EN_BIT]),
    .baseEnIn (ctrlByte[BASE_EN_BIT]),
    .baseOut  (baseOut),
    .divOut   (divOut)
  );
endmodule

// File: tb/test_progClockDivider.sv
`timescale 1ns/1ps
module test_progClockDivider;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] divSel = 8'd0;
  logic [7:0] ctrlByte = 8'd0;
  logic       baseOut, divOut;
  int         nChecks = 0;
  int         nFails = 0;
  logic       prevS, curS;

  always #4 clk = ~clk;

  progClockDivider i_progClockDivider (
    .clk(clk), .rstN(rstN), .divSel(divSel), .ctrlByte(ctrlByte),
    .baseOut(baseOut), .divOut(divOut)
  );

  function automatic int expPeriod(input int n, input bit mode);
    return mode ? 2 * (n + 1) : n + 1;
  endfunction

  function automatic int expHigh(input int n, input bit mode);
    return mode ? n + 1 : 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample divOut in the high phase of clk, 2 ns after the rising edge
  task automatic sampleHi();
    @(posedge clk); #2;
    prevS = curS;
    curS  = divOut;
  endtask

  task automatic waitRise(input string req);
    int k;
    for (k = 0; k < 2000; k++) begin
      sampleHi();
      if (!prevS && curS) break;
    end
    if (k == 2000) check({req, " rise timeout"}, 0, 1);
  endtask

  // called just after a rise: returns period and high count to the next rise
  task automatic periodFromRise(output int per, output int hi);
    per = 0; hi = 1;
    for (int k = 0; k < 2000; k++) begin
      sampleHi();
      per++;
      if (!prevS && curS) break;
      if (curS) hi++;
    end
  endtask

  task automatic measure(input string req, input int n, input bit mode);
    int per, hi;
    waitRise(req);
    periodFromRise(per, hi);
    check({req, " period"}, per, expPeriod(n, mode));
    check({req, " high"}, hi, expHigh(n, mode));
  endtask

  task automatic checkPass(input string req, input bit en);
    repeat (3) sampleHi();
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #2; check({req, " high phase"}, divOut, en);
      #4;                check({req, " low phase"}, divOut, 0);
    end
  endtask

  task automatic checkBase(input string req, input bit en);
    repeat (2) @(posedge clk);
    @(posedge clk); #2; check({req, " base high"}, baseOut, en);
    #4;                check({req, " base low"}, baseOut, 0);
  endtask

  task automatic setCfg(input int n, input bit mode, input bit baseEn,
                        input bit divEn, input logic [4:0] junk);
    divSel   = n[7:0];
    ctrlByte = {junk[3:0], divEn, baseEn, junk[4], mode};
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int per, hi;
    void'($urandom(32'd90210));
    curS = 1'b0; prevS = 1'b0;
    setCfg(3, 1'b0, 1'b1, 1'b1, 5'd0);
    // R9: reset state
    repeat (3) @(posedge clk);
    #2; check("R9 base in reset", baseOut, 0);
    check("R9 div in reset", divOut, 0);
    #4; check("R9 div in reset low phase", divOut, 0);
    @(negedge clk); rstN = 1'b1;

    // R1 and R5
    measure("R1 mode0 N=3", 3, 1'b0);
    checkBase("R5 enabled", 1'b1);
    setCfg(3, 1'b0, 1'b0, 1'b1, 5'd0);
    checkBase("R5 disabled", 1'b0);

    // R2 pass-through
    setCfg(0, 1'b0, 1'b0, 1'b1, 5'd0);
    checkPass("R2 N=0", 1'b1);

    // R3 mode 1
    setCfg(4, 1'b1, 1'b1, 1'b1, 5'd0);
    measure("R3 mode1 N=4", 4, 1'b1);
    setCfg(0, 1'b1, 1'b1, 1'b1, 5'd0);
    measure("R3 mode1 N=0", 0, 1'b1);

    // R6 disabled divided output
    setCfg(2, 1'b0, 1'b1, 1'b0, 5'd0);
    repeat (10) @(posedge clk);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #2; if (divOut) hi++;
      #4; if (divOut) hi++;
    end
    check("R6 disabled stays low", hi, 0);

    // R4 ignored bits, compared against the same settings with them clear
    setCfg(5, 1'b0, 1'b1, 1'b1, 5'b11111);
    measure("R4 junk bits mode0", 5, 1'b0);
    checkBase("R4 junk bits base", 1'b1);
    setCfg(0, 1'b0, 1'b0, 1'b1, 5'b10110);
    checkPass("R4 junk bits pass", 1'b1);
    checkBase("R4 junk bits base off", 1'b0);

    // R7 change right after a boundary: running period keeps old value
    setCfg(5, 1'b0, 1'b1, 1'b1, 5'd0);
    waitRise("R7");
    waitRise("R7");
    setCfg(2, 1'b0, 1'b1, 1'b1, 5'd0);
    periodFromRise(per, hi);
    check("R7 old period completes", per, 6);
    periodFromRise(per, hi);
    check("R7 new period", per, 3);
    // R7 mode change mid-period
    setCfg(3, 1'b1, 1'b1, 1'b1, 5'd0);
    periodFromRise(per, hi);
    check("R7 mode change waits", per, 3);
    periodFromRise(per, hi);
    check("R7 mode1 after switch period", per, 8);
    check("R7 mode1 after switch high", hi, 4);

    // R8 disable inside the high phase of mode 1
    setCfg(3, 1'b1, 1'b1, 1'b1, 5'd0);
    waitRise("R8");
    waitRise("R8");
    sampleHi();
    setCfg(3, 1'b1, 1'b1, 1'b0, 5'd0);
    hi = 2;
    for (int k = 0; k < 10; k++) begin
      sampleHi();
      if (!curS) break;
      hi++;
    end
    check("R8 high phase not truncated", hi, 4);
    hi = 0;
    for (int k = 0; k < 20; k++) begin
      sampleHi();
      if (curS) hi++;
    end
    check("R8 low after disable", hi, 0);

    // R10 extremes
    setCfg(255, 1'b0, 1'b1, 1'b1, 5'd0);
    measure("R10 mode0 N=255", 255, 1'b0);
    setCfg(255, 1'b1, 1'b1, 1'b1, 5'd0);
    measure("R10 mode1 N=255", 255, 1'b1);

    // random mix
    for (int it = 0; it < 16; it++) begin
      int  n;
      bit  mode;
      n    = $urandom % 12;
      mode = $urandom % 2;
      setCfg(n, mode, 1'b1, 1'b1, 5'($urandom));
      if (!mode && n == 0) checkPass("R2 random", 1'b1);
      else if (mode)       measure("R3 random", n, mode);
      else                 measure("R1 random", n, mode);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule